// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers interrupt events from three timers, a watchdog, a serial port (receive-complete and transmit-complete), a clock alarm and a supply-low comparator. It keeps a sticky flag for each edge-type event. It masks the pending sources with a per-source enable and a global enable, and ranks them in a two-group scheme with a fixed order inside each group. The winner goes to the CPU as a request with a vector index. The CPU takes it with a one-cycle acknowledge and later gives it back with a return pulse.

Flags clear in different ways. The flags of two timers clear when their own vector is acknowledged. Every other flag stays set until software writes a clear mask. The supply-low source has no flag: it follows its input level. It outranks everything, whatever its priority bit says, and the global enable does not gate it. The block records the priority level of each acknowledged vector, so only a strictly higher level can interrupt a handler that is running.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Flag bits (bit 0 timer A, 1 timer B, 2 timer C, 3 watchdog, 4 serial receive, 5 serial transmit, 6 alarm) set the cycle after their event pulse, whatever the enables are. A software clear (`sw_clr_we` with a mask bit at 1) clears the bit on the next edge, unless an event for that bit arrives in the same cycle, in which case the bit ends set.
- R2: Flag bits 0 and 1 clear on the edge where the CPU acknowledges vector 1 or vector 2 respectively, while the request is high. Without an acknowledge they stay set.
- R3: Flag bits 2, 3 and 6 are never changed by an acknowledge. Only a software clear removes them.
- R4: Vector 3 is pending while flag 4 or flag 5 is set. Its enable is `src_en[3]` and its priority bit is `src_hi[3]`. An acknowledge of vector 3 changes neither flag.
- R5: Vector 0 (supply-low) is pending exactly while `pfail_low` and `src_en[0]` are both high, whatever `glb_en` is. It has its own top level, above the high group, and `src_hi[0]` is ignored.
- R6: Vectors 1 to 6 are pending only while their flag, their `src_en` bit and `glb_en` are all set. Vector mapping: 1 timer A, 2 timer B, 3 serial, 4 timer C, 5 watchdog, 6 alarm.
- R7: Among pending vectors, the top level beats the high group (`src_hi` bit 1), and the high group beats the low group. Within a level the lowest vector index wins. `irq_vec` shows the winner.
- R8: An acknowledge while `irq_req` is high marks the winner's level as in service. `irq_req` is high only when the winner's level is strictly above every level in service. `irq_reti` frees the highest level in service.
- R9: `wake` is high while flag 6 and `src_en[6]` are both set, whatever `glb_en` and the in-service state are.
- R10: After reset all flags are clear and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tmr_a | input | 1 | Timer A overflow pulse |
| ev_tmr_b | input | 1 | Timer B overflow pulse |
| ev_tmr_c | input | 1 | Timer C overflow pulse |
| ev_wdog | input | 1 | Watchdog interval pulse |
| ev_rx_done | input | 1 | Serial word fully received |
| ev_tx_done | input | 1 | Serial word fully sent |
| ev_alarm | input | 1 | Clock alarm pulse |
| pfail_low | input | 1 | Supply-low level |
| glb_en | input | 1 | Global enable for vectors 1 to 6 |
| src_en | input | 7 | Per-vector enable |
| src_hi | input | 7 | Per-vector high-group bit (bit 0 unused) |
| sw_clr_we | input | 1 | Software clear strobe |
| sw_clr_mask | input | 7 | Flag bits to clear |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_reti | input | 1 | Handler return pulse |
| flags | output | 7 | Flag bits |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 3 | Winning vector index |
| wake | output | 1 | Alarm wake-up |

## Verification
The assertions assume three things. Event inputs are one-cycle pulses. An acknowledge counts only while the request is high. A return pulse comes only after an acknowledge. The acknowledge-clear properties also assume that no event for the same flag arrives in the acknowledge cycle. The bench drives events, clears, acknowledges and returns at random, and it applies returns only while its own model has a level in service. Where an acknowledge meets an event for a timer flag, it checks the result against the model rather than the assertion.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tmr_a,
  input  logic       ev_tmr_b,
  input  logic       ev_tmr_c,
  input  logic       ev_wdog,
  input  logic       ev_rx_done,
  input  logic       ev_tx_done,
  input  logic       ev_alarm,
  input  logic       pfail_low,
  input  logic       glb_en,
  input  logic [6:0] src_en,
  input  logic [6:0] src_hi,
  input  logic       sw_clr_we,
  input  logic [6:0] sw_clr_mask,
  input  logic       irq_ack,
  input  logic       irq_reti,
  output logic [6:0] flags,
  output logic       irq_req,
  output logic [2:0] irq_vec,
  output logic       wake
);

  logic [6:0] flag_q, flag_d, ev, clr, pend;
  logic [2:0] insv_q, insv_d, insv_top;
  logic [1:0] thr, win_lvl;
  logic [2:0] win_vec;
  logic       found, take;

  assign ev = {ev_alarm, ev_tx_done, ev_rx_done, ev_wdog, ev_tmr_c, ev_tmr_b, ev_tmr_a};

  assign pend[0] = pfail_low & src_en[0];
  assign pend[1] = flag_q[0] & src_en[1] & glb_en;
  assign pend[2] = flag_q[1] & src_en[2] & glb_en;
  assign pend[3] = (flag_q[4] | flag_q[5]) & src_en[3] & glb_en;
  assign pend[4] = flag_q[2] & src_en[4] & glb_en;
  assign pend[5] = flag_q[3] & src_en[5] & glb_en;
  assign pend[6] = flag_q[6] & src_en[6] & glb_en;

  always_comb begin
    found   = 1'b0;
    win_vec = 3'd0;
    win_lvl = 2'd0;
    for (int lv = 2; lv >= 0; lv--) begin
      for (int v = 0; v < 7; v++) begin
        if (!found && pend[v] &&
            ((v == 0) ? (lv == 2) : (lv == (src_hi[v] ? 1 : 0)))) begin
          found   = 1'b1;
          win_vec = 3'(v);
          win_lvl = 2'(lv);
        end
      end
    end
  end

  assign thr      = insv_q[2] ? 2'd3 : insv_q[1] ? 2'd2 : insv_q[0] ? 2'd1 : 2'd0;
  assign insv_top = insv_q[2] ? 3'b100 : insv_q[1] ? 3'b010 : insv_q[0] ? 3'b001 : 3'b000;

  assign irq_req = found && (win_lvl >= thr);
  assign irq_vec = win_vec;
  assign take    = irq_ack & irq_req;
  assign wake    = flag_q[6] & src_en[6];
  assign flags   = flag_q;

  assign clr    = (sw_clr_we ? sw_clr_mask : 7'd0)
                | {5'd0, take && (win_vec == 3'd2), take && (win_vec == 3'd1)};
  assign flag_d = ev | (flag_q & ~clr);
  assign insv_d = (insv_q & ~(irq_reti ? insv_top : 3'b000))
                | (take ? (3'b001 << win_lvl) : 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      insv_q <= '0;
    end else begin
      flag_q <= flag_d;
      insv_q <= insv_d;
    end
  end

  assert_hw_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmr_c |=> flags[2]);

  assert_ack_clears_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == 3'd1 && !ev_tmr_a) |=> !flags[0]);

  assert_c_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !(sw_clr_we && sw_clr_mask[2])) |=> flags[2]);

  assert_rx_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[4] && !(sw_clr_we && sw_clr_mask[4])) |=> flags[4]);

  assert_pfail_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pfail_low && src_en[0] && insv_q == 3'b000) |-> (irq_req && irq_vec == 3'd0));

  assert_no_req_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !(pfail_low && src_en[0])) |-> !irq_req);

  assert_top_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    insv_q[2] |-> !irq_req);

endmodule

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [6:0] ev = 0;
  logic pfail_low = 0, glb_en = 0, sw_clr_we = 0, irq_ack = 0, irq_reti = 0;
  logic [6:0] src_en = 0, src_hi = 0, sw_clr_mask = 0;
  logic [6:0] flags;
  logic irq_req, wake;
  logic [2:0] irq_vec;

  int compared = 0, mismatched = 0;
  string phase = "R10";
  bit m_flag[7];
  int stack[$];

  always #10 clk = ~clk;

  irq_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .ev_tmr_a(ev[0]), .ev_tmr_b(ev[1]), .ev_tmr_c(ev[2]), .ev_wdog(ev[3]),
    .ev_rx_done(ev[4]), .ev_tx_done(ev[5]), .ev_alarm(ev[6]),
    .pfail_low(pfail_low), .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi),
    .sw_clr_we(sw_clr_we), .sw_clr_mask(sw_clr_mask),
    .irq_ack(irq_ack), .irq_reti(irq_reti),
    .flags(flags), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  function automatic int level_of(int v);
    if (v == 0) return 2;
    return src_hi[v] ? 1 : 0;
  endfunction

  function automatic bit pending(int v);
    case (v)
      0: return pfail_low && src_en[0];
      1: return m_flag[0] && src_en[1] && glb_en;
      2: return m_flag[1] && src_en[2] && glb_en;
      3: return (m_flag[4] || m_flag[5]) && src_en[3] && glb_en;
      4: return m_flag[2] && src_en[4] && glb_en;
      5: return m_flag[3] && src_en[5] && glb_en;
      default: return m_flag[6] && src_en[6] && glb_en;
    endcase
  endfunction

  task automatic model_eval(output bit req, output int vec, output int lvl);
    req = 0; vec = -1; lvl = -1;
    for (int l = 2; l >= 0 && vec < 0; l--)
      for (int v = 0; v < 7 && vec < 0; v++)
        if (pending(v) && level_of(v) == l) begin vec = v; lvl = l; end
    if (vec >= 0) req = (stack.size() == 0) || (lvl > stack[$]);
  endtask

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL [%s] %s actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit req; int vec, lvl; bit taken;
    #1;
    model_eval(req, vec, lvl);
    for (int i = 0; i < 7; i++) check($sformatf("R1 flag%0d", i), flags[i], m_flag[i]);
    check("R8 irq_req", irq_req, req);
    if (req) check("R7 irq_vec", irq_vec, vec);
    check("R9 wake", wake, m_flag[6] && src_en[6]);
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) m_flag[i] = 0;
      stack.delete();
    end else begin
      taken = irq_ack && req;
      for (int i = 0; i < 7; i++) begin
        if (ev[i]) m_flag[i] = 1;
        else if (sw_clr_we && sw_clr_mask[i]) m_flag[i] = 0;
        else if (taken && ((i == 0 && vec == 1) || (i == 1 && vec == 2))) m_flag[i] = 0;
      end
      if (irq_reti && stack.size() > 0) void'(stack.pop_back());
      if (taken) stack.push_back(lvl);
    end
    @(posedge clk); @(negedge clk);
    ev = 0; sw_clr_we = 0; sw_clr_mask = 0; irq_ack = 0; irq_reti = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL [watchdog] run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    phase = "R10"; idle(3);
    rst_n = 1; idle(1);

    phase = "R1"; ev = 7'h7F; step(); idle(1);
    sw_clr_we = 1; sw_clr_mask = 7'h7F; ev[2] = 1; step(); idle(1);
    sw_clr_we = 1; sw_clr_mask = 7'h04; step(); idle(1);

    phase = "R6"; ev = 7'h01; step(); idle(2);
    src_en = 7'h7F; idle(2);
    glb_en = 1; idle(1);

    phase = "R2"; irq_ack = 1; step(); idle(1);
    irq_reti = 1; step();
    ev[1] = 1; step(); idle(1);
    irq_ack = 1; step(); irq_reti = 1; step();

    phase = "R3"; ev[2] = 1; ev[3] = 1; step();
    irq_ack = 1; step(); irq_reti = 1; step(); idle(1);
    irq_ack = 1; step(); irq_reti = 1; step();
    sw_clr_we = 1; sw_clr_mask = 7'h0C; step();

    phase = "R4"; ev[4] = 1; step(); irq_ack = 1; step(); irq_reti = 1; step();
    ev[5] = 1; sw_clr_we = 1; sw_clr_mask = 7'h10; step(); idle(1);
    irq_ack = 1; step(); irq_reti = 1; step();
    sw_clr_we = 1; sw_clr_mask = 7'h30; step();

    phase = "R7"; ev = 7'h4F; src_hi = 7'h40; step(); idle(1);
    src_hi = 7'h20; idle(1); src_hi = 7'h00; idle(1);

    phase = "R8"; irq_ack = 1; step(); idle(1);
    src_hi = 7'h20; idle(1);
    irq_ack = 1; step(); idle(1);
    irq_reti = 1; step(); irq_reti = 1; step(); idle(1);

    phase = "R5"; glb_en = 0; pfail_low = 1; src_hi = 7'h7F; idle(2);
    glb_en = 1; idle(1);
    irq_ack = 1; step(); idle(2);
    pfail_low = 0; idle(1); irq_reti = 1; step();
    src_en[0] = 0; pfail_low = 1; idle(2); pfail_low = 0; src_en[0] = 1;

    phase = "R9"; glb_en = 0; ev[6] = 1; step(); idle(1);
    src_en[6] = 0; idle(1); src_en[6] = 1; glb_en = 1;
    sw_clr_we = 1; sw_clr_mask = 7'h7F; step();

    phase = "R7 random";
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < 7; i++) ev[i] = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) begin sw_clr_we = 1; sw_clr_mask = 7'($urandom); end
      if ($urandom_range(0, 31) == 0) src_en = 7'($urandom);
      if ($urandom_range(0, 31) == 0) src_hi = 7'($urandom);
      if ($urandom_range(0, 63) == 0) glb_en = ~glb_en;
      if ($urandom_range(0, 63) == 0) pfail_low = ~pfail_low;
      irq_ack = ($urandom_range(0, 3) == 0);
      irq_reti = (stack.size() > 0) && ($urandom_range(0, 5) == 0);
      step();
    end

    phase = "R10"; rst_n = 0; idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule